// File: doc/BRIEF.md
# Cascadable Parity Generator and Checker

The block protects data words with one parity bit carried on a shared, bidirectional parity line. Its building block is a 9-input unit with a single direction control. With the control low the unit generates: it drives the line with a bit that makes the ten bits (nine data plus parity) odd, and it holds its active-low error flag high. With the control high the unit checks: it releases the line, samples the incoming parity bit and pulls the error flag low when the ten bits do not have odd parity. The bidirectional line is split into a drive value, an output enable and a sampled input.

Longer words are covered by chaining units. The lowest unit takes nine data bits. Each further unit takes eight new data bits, and its first input comes from the generated parity of the unit below. Every unit except the last is kept in generate mode. The last unit's line and error flag form the external interface. The block is purely combinational.

Top module: `parity_cascade`

## Requirements
- R1: In a single unit (N_STAGES=1) the generated bit on parity_o is high exactly when an even number of the nine data inputs are high, so the ten bits have odd parity. parity_o shows this value in both modes.
- R2: With chk_en_i low (generate mode), parity_oe_o is 1 and err_no is 1 for every data pattern and every parity_i value.
- R3: With chk_en_i high (check mode), parity_oe_o is 0.
- R4: In check mode, err_no is 0 when an even number of the data inputs are high and parity_i is 0.
- R5: In check mode, err_no is 0 when an odd number of the data inputs are high and parity_i is 1. For the other two combinations err_no is 1.
- R6: In the cascade, stage 0 takes data_i[8:0]. Stage k (k≥1) takes data_i[8k+8:8k+1] together with the parity generated by stage k-1. The word is 9+8·(N_STAGES-1) bits wide. parity_o equals the XOR of all word bits, inverted when N_STAGES is odd.
- R7: In the cascade's check mode, err_no is 0 exactly when parity_i differs from parity_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| data_i | input | WORD_W | Data word, 9+8·(N_STAGES-1) bits |
| chk_en_i | input | 1 | Direction: 0 generates and drives the line, 1 checks |
| parity_i | input | 1 | Value sampled from the parity line |
| parity_o | output | 1 | Generated parity value driven onto the line |
| parity_oe_o | output | 1 | Line output enable, high in generate mode |
| err_no | output | 1 | Active-low parity error flag |

## Verification
The assertions are immediate checks inside the combinational logic. They assume that every input is at a known 0 or 1, and they skip evaluation while any input is unknown, for example before the bench first drives a value. The bench always drives every bit of data_i, chk_en_i and parity_i together and waits a settling delay before each sample. A nine-bit unit gets all 512 patterns in both modes with both line values. A two-stage cascade gets all 17-bit words, with the line set to the correct value and then to the flipped value.

// File: rtl/parity_pkg.sv
package parity_pkg;
  localparam int unsigned UNIT_W = 9;
  localparam int unsigned FEED_W = UNIT_W - 1;

  function automatic int unsigned word_width(input int unsigned stages);
    return UNIT_W + FEED_W * (stages - 1);
  endfunction
endpackage

// File: rtl/parity_xor_chain.sv
module parity_xor_chain #(
  parameter int unsigned WIDTH = 9
) (
  input  logic [WIDTH-1:0] bits_i,
  output logic             odd_o
);
  logic [WIDTH:0] acc;

  assign acc[0] = 1'b0;
  for (genvar i = 0; i < WIDTH; i++) begin : g_xor
    assign acc[i+1] = acc[i] ^ bits_i[i];
  end
  assign odd_o = acc[WIDTH];

  always_comb begin
    if (!$isunknown(bits_i)) begin
      // R1
      odd_ones_chk: assert (odd_o == ($countones(bits_i) % 2 == 1))
        else $error("odd_ones_chk");
    end
  end
endmodule

// File: rtl/parity_unit.sv
module parity_unit
  import parity_pkg::*;
(
  input  logic [UNIT_W-1:0] data_i,
  input  logic              chk_en_i,
  input  logic              line_i,
  output logic              line_o,
  output logic              line_oe_o,
  output logic              err_no
);
  logic odd_w;

  parity_xor_chain #(.WIDTH(UNIT_W)) tree_i (
    .bits_i (data_i),
    .odd_o  (odd_w)
  );

  // generated bit completes odd parity over ten bits
  assign line_o    = ~odd_w;
  assign line_oe_o = ~chk_en_i;
  // mismatch: data parity equals the sampled bit -> even total
  assign err_no    = ~(chk_en_i & (odd_w ~^ line_i));

  always_comb begin
    if (!$isunknown({data_i, chk_en_i, line_i})) begin
      // R2
      gen_err_idle_chk: assert (chk_en_i || err_no)
        else $error("gen_err_idle_chk");
      // R3
      chk_release_chk: assert (!chk_en_i || !line_oe_o)
        else $error("chk_release_chk");
      // R5
      chk_flag_chk: assert (!chk_en_i || (err_no == ^{data_i, line_i}))
        else $error("chk_flag_chk");
    end
  end
endmodule

// File: rtl/parity_cascade.sv
module parity_cascade
  import parity_pkg::*;
#(
  parameter int unsigned N_STAGES = 2,
  localparam int unsigned WORD_W  = word_width(N_STAGES)
) (
  input  logic [WORD_W-1:0] data_i,
  input  logic              chk_en_i,
  input  logic              parity_i,
  output logic              parity_o,
  output logic              parity_oe_o,
  output logic              err_no
);
  localparam int unsigned LAST = N_STAGES - 1;

  logic [N_STAGES-1:0] par_w;
  logic [N_STAGES-1:0] oe_w;
  logic [N_STAGES-1:0] err_w;

  for (genvar k = 0; k < N_STAGES; k++) begin : g_stage
    logic [UNIT_W-1:0] in_w;
    logic              chk_w;
    logic              line_w;

    if (k == 0) begin : g_first
      assign in_w = data_i[UNIT_W-1:0];
    end else begin : g_next
      assign in_w = {data_i[FEED_W*k+FEED_W:FEED_W*k+1], par_w[k-1]};
    end

    if (k == LAST) begin : g_edge
      assign chk_w  = chk_en_i;
      assign line_w = parity_i;
    end else begin : g_inner
      assign chk_w  = 1'b0;
      assign line_w = par_w[k];
    end

    parity_unit unit_i (
      .data_i    (in_w),
      .chk_en_i  (chk_w),
      .line_i    (line_w),
      .line_o    (par_w[k]),
      .line_oe_o (oe_w[k]),
      .err_no    (err_w[k])
    );
  end

  assign parity_o    = par_w[LAST];
  // inner stages always generate (oe=1, err_n=1), so reduction exposes the last stage
  assign parity_oe_o = &oe_w;
  assign err_no      = &err_w;

  always_comb begin
    if (!$isunknown({data_i, chk_en_i, parity_i})) begin
      // R6
      chain_par_chk: assert (parity_o == ((^data_i) ^ (N_STAGES % 2 == 1)))
        else $error("chain_par_chk");
      // R7
      chain_err_chk: assert (!chk_en_i || (err_no == (parity_i == parity_o)))
        else $error("chain_err_chk");
    end
  end
endmodule

// File: tb/parity_cascade_tb.sv
module parity_cascade_tb_top;
  localparam int unsigned W1 = 9;
  localparam int unsigned W2 = 17;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 1'b0;

  logic [W2-1:0] d2;
  logic          chk2, line2, par2, oe2, err2;
  logic [W1-1:0] d1;
  logic          chk1, line1, par1, oe1, err1;

  parity_cascade #(.N_STAGES(2)) dut_i (
    .data_i(d2), .chk_en_i(chk2), .parity_i(line2),
    .parity_o(par2), .parity_oe_o(oe2), .err_no(err2)
  );

  parity_cascade #(.N_STAGES(1)) unit_i (
    .data_i(d1), .chk_en_i(chk1), .parity_i(line1),
    .parity_o(par1), .parity_oe_o(oe1), .err_no(err1)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      if (errors < 20) $display("FAIL %s act=%b exp=%b", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000 && !done) begin
      errors++;
      $display("FAIL watchdog act=%0d exp<190000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    d1 = '0; chk1 = 1'b0; line1 = 1'b0;
    d2 = '0; chk2 = 1'b0; line2 = 1'b0;
    #5;
    // idle state: generate mode, zero data
    chk("R2", oe1, 1'b1);
    chk("R2", err1, 1'b1);
    chk("R1", par1, 1'b1);

    // single unit, exhaustive
    for (int p = 0; p < 512; p++) begin
      for (int m = 0; m < 4; m++) begin
        logic odd_cnt;
        d1 = p[W1-1:0]; chk1 = m[1]; line1 = m[0];
        odd_cnt = ($countones(p[W1-1:0]) % 2) == 1;
        #1;
        chk("R1", par1, ~odd_cnt);
        if (!chk1) begin
          chk("R2", oe1, 1'b1);
          chk("R2", err1, 1'b1);
        end else begin
          chk("R3", oe1, 1'b0);
          if (!odd_cnt && !line1) chk("R4", err1, 1'b0);
          else if (odd_cnt && line1) chk("R5", err1, 1'b0);
          else chk("R5", err1, 1'b1);
        end
      end
    end

    // two-stage cascade, exhaustive over the 17-bit word
    for (int p = 0; p < (1 << W2); p++) begin
      logic ref_par;
      d2 = p[W2-1:0];
      ref_par = ^p[W2-1:0];  // N_STAGES even: no inversion
      chk2 = 1'b0; line2 = ~ref_par;
      #1;
      chk("R6", par2, ref_par);
      chk("R2", err2 & oe2, 1'b1);
      chk2 = 1'b1; line2 = ref_par;
      #1;
      chk("R7", err2, 1'b1);
      chk("R3", oe2, 1'b0);
      line2 = ~ref_par;
      #1;
      chk("R7", err2, 1'b0);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule